// File: doc/BRIEF.md
# Remote Block Request Tracker

This block sits on one cluster's local snooping bus. It keeps a small, fully associative table of outstanding requests for memory blocks that cannot be served inside the cluster, either because they are homed elsewhere or because another cluster holds them dirty. When a local bus read or read-exclusive misses, the tracker claims a free entry. It blocks the requesting processor from arbitration and tells it to retry. The network reply later fills the entry and releases the processor, and the retried access is served from the entry.

Read-exclusive replies carry the number of invalidation acknowledgements that are still outstanding. The entry stays allocated until all of them have arrived, including the single acknowledgement from home that follows a dirty transfer. An invalidation seen while a read is pending marks its entry stale. The reply still releases the processor, but the retried access gets a negative acknowledgement and must start over. The tracker can also accept a dirty block handed over by a local owner, and it then acts as the cluster's owner of that block.

Top module: `rac_tracker`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), bus_retry, bus_hit, bus_nak, arb_mask and err_flag are all 0 and no entry is allocated.
- R2: A read (bus_cmd 2'b00) or read-exclusive (bus_cmd 2'b01) that matches no entry, with a free entry available, gives bus_retry=1 one cycle later and sets arb_mask bit bus_id. A repeated access to a block whose entry is still waiting for its reply gives bus_retry again and leaves arb_mask unchanged.
- R3: With all 4 entries allocated, a miss gets bus_retry and allocates nothing: arb_mask keeps its value and a later reply for that address matches no entry.
- R4: A reply (rsp_valid) for a pending entry clears the requester's arb_mask bit. The retried read gets bus_hit with bus_rdata equal to the reply data. The entry then stays as a shared copy, and later reads of the block from any requester also hit.
- R5: A read-exclusive reply with rsp_acks=0 frees the entry when the retried access is served, so the next access to that block misses and allocates again.
- R6: A read-exclusive reply with rsp_acks=N>0 is served on the retry, but the entry stays allocated until N acknowledgements (ack_valid) have arrived. Meanwhile, accesses to the block get bus_retry without allocation or masking. The Nth acknowledgement frees the entry.
- R7: Acknowledgements arriving before the retried access count down the same counter. With rsp_acks=1 (dirty transfer) and the home acknowledgement already received, the retried access is served and the entry is freed at once.
- R8: An invalidation (inv_valid) for a block with a pending read marks the entry stale. The later reply still clears the mask bit. The retried access gets bus_nak=1 and bus_hit=0, and the entry is freed.
- R9: An invalidation does not mark a pending read-exclusive entry stale. An invalidation for a shared entry frees that entry.
- R10: A dirty fill (bus_cmd 2'b10, data on bus_wdata) for an untracked block allocates an owner entry without masking or any bus response. Reads then hit with the fill data and keep the entry. A read-exclusive hits and frees it.
- R11: A reply matching no pending entry, or an acknowledgement matching no entry with a nonzero count, changes no entry and sets err_flag, which stays 1 until reset.
- R12: A read-exclusive to a shared entry gets bus_retry. The entry returns to pending exclusive for the new requester, and that requester's arb_mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_cmd | input | 2 | 00 read, 01 read-exclusive, 10 dirty fill |
| bus_addr | input | ADDR_W | Block address |
| bus_id | input | REQ_W | Requesting processor |
| bus_wdata | input | DATA_W | Block data for dirty fill |
| bus_retry | output | 1 | Access must be retried (registered) |
| bus_hit | output | 1 | Access served from tracker (registered) |
| bus_nak | output | 1 | Stale entry, access refused (registered) |
| bus_rdata | output | DATA_W | Data returned with bus_hit |
| arb_mask | output | NUM_REQ | Bit i set: processor i blocked from arbitration |
| rsp_valid | input | 1 | Network data reply |
| rsp_addr | input | ADDR_W | Reply block address |
| rsp_data | input | DATA_W | Reply block data |
| rsp_acks | input | ACK_W | Outstanding invalidation acknowledgements |
| ack_valid | input | 1 | Invalidation acknowledgement |
| ack_addr | input | ADDR_W | Acknowledged block address |
| inv_valid | input | 1 | Snooped invalidation |
| inv_addr | input | ADDR_W | Invalidated block address |
| err_flag | output | 1 | Sticky unmatched reply/acknowledgement |

## Verification
Every bus access is answered exactly one clock after the edge that captures it. Changes to arb_mask caused by an access, reply, acknowledgement or invalidation show up after that same single edge, and so does a new err_flag. The bench drives each stimulus on a falling edge, lets one rising edge pass, and samples on the following falling edge. That is precisely where each result is due, and the stimulus is removed in the same step. Effects that outlast one cycle, such as held entries, freed entries and the sticky error, are checked through later bus accesses and the mask they produce.

// File: rtl/rac_pkg.sv
// Shared types for the remote block request tracker.
// Assumes: bus commands are encoded on 2 bits as listed below.
package rac_pkg;
    typedef enum logic [2:0] {
        ST_PEND    = 3'd0,   // waiting for network reply, requester masked
        ST_READY   = 3'd1,   // reply held, waiting for the retried access
        ST_NAKD    = 3'd2,   // stale reply, next access gets a NAK
        ST_SHARED  = 3'd3,   // clean shared copy kept
        ST_SDIRTY  = 3'd4,   // shared-dirty, tracker owns the block
        ST_ACKWAIT = 3'd5    // data handed out, invalidation acks outstanding
    } rac_state_t;

    localparam logic [1:0] CMD_READ  = 2'b00;
    localparam logic [1:0] CMD_READX = 2'b01;
    localparam logic [1:0] CMD_DFILL = 2'b10;
endpackage

// File: rtl/rac_entry.sv
// One tracker entry: tag match on every input stream and the entry's own state machine.
// Assumes: the top allocates only on a miss, and it answers retry (so this entry
// ignores the access) whenever a reply, ack or invalidation hits the entry in the same cycle.
module rac_entry
    import rac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int REQ_W  = 2,
    parameter int ACK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              bus_valid,
    input  logic [1:0]        bus_cmd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REQ_W-1:0]  bus_id,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [ACK_W-1:0]  rsp_acks,
    input  logic              ack_valid,
    input  logic [ADDR_W-1:0] ack_addr,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              valid,
    output rac_state_t        state,
    output logic [REQ_W-1:0]  req_id,
    output logic [DATA_W-1:0] data,
    output logic              hit_bus,
    output logic              hit_rsp,
    output logic              hit_ack,
    output logic              hit_inv
);
    logic [ADDR_W-1:0] tag;
    logic [ACK_W-1:0]  acks;
    logic              excl;
    logic              stale;

    // Match decode for each input stream.
    always_comb begin
        hit_bus = bus_valid && valid && (tag == bus_addr);
        hit_rsp = rsp_valid && valid && (state == ST_PEND) && (tag == rsp_addr);
        hit_ack = ack_valid && valid && (tag == ack_addr) && (acks != '0)
                  && ((state == ST_READY) || (state == ST_ACKWAIT));
        hit_inv = inv_valid && valid && (tag == inv_addr)
                  && (((state == ST_PEND) && !excl) || (state == ST_SHARED));
    end

    // Entry state update, one event per cycle in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            state  <= ST_PEND;
            tag    <= '0;
            req_id <= '0;
            data   <= '0;
            acks   <= '0;
            excl   <= 1'b0;
            stale  <= 1'b0;
        end else if (alloc) begin
            valid  <= 1'b1;
            tag    <= bus_addr;
            req_id <= bus_id;
            acks   <= '0;
            stale  <= 1'b0;
            if (bus_cmd == CMD_DFILL) begin
                state <= ST_SDIRTY;
                data  <= bus_wdata;
                excl  <= 1'b0;
            end else begin
                state <= ST_PEND;
                excl  <= (bus_cmd == CMD_READX);
            end
        end else if (hit_rsp) begin
            if (stale) begin
                state <= ST_NAKD;
            end else begin
                state <= ST_READY;
                data  <= rsp_data;
                acks  <= rsp_acks;
            end
        end else if (hit_ack) begin
            acks <= acks - ACK_W'(1);
            if ((state == ST_ACKWAIT) && (acks == ACK_W'(1))) valid <= 1'b0;
        end else if (hit_inv) begin
            if (state == ST_SHARED) valid <= 1'b0;
            else                    stale <= 1'b1;
        end else if (hit_bus) begin
            case (state)
                ST_READY: if (bus_cmd != CMD_DFILL) begin
                    if (!excl)              state <= ST_SHARED;
                    else if (acks == '0)    valid <= 1'b0;
                    else                    state <= ST_ACKWAIT;
                end
                ST_NAKD: if (bus_cmd != CMD_DFILL) valid <= 1'b0;
                ST_SHARED: begin
                    if (bus_cmd == CMD_READX) begin
                        state  <= ST_PEND;
                        excl   <= 1'b1;
                        req_id <= bus_id;
                    end else if (bus_cmd == CMD_DFILL) begin
                        state <= ST_SDIRTY;
                        data  <= bus_wdata;
                    end
                end
                ST_SDIRTY: begin
                    if (bus_cmd == CMD_READX)      valid <= 1'b0;
                    else if (bus_cmd == CMD_DFILL) data  <= bus_wdata;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rac_tracker.sv
// Remote block request tracker: entry table, allocation, bus response, arbitration mask.
// Assumes: tags in the table are unique (allocation happens only on a miss);
// bus responses are registered and appear one cycle after the access.
module rac_tracker
    import rac_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int NUM_REQ     = 4,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int ACK_W       = 4,
    parameter int REQ_W       = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic [1:0]         bus_cmd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REQ_W-1:0]   bus_id,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_retry,
    output logic               bus_hit,
    output logic               bus_nak,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_REQ-1:0] arb_mask,
    input  logic               rsp_valid,
    input  logic [ADDR_W-1:0]  rsp_addr,
    input  logic [DATA_W-1:0]  rsp_data,
    input  logic [ACK_W-1:0]   rsp_acks,
    input  logic               ack_valid,
    input  logic [ADDR_W-1:0]  ack_addr,
    input  logic               inv_valid,
    input  logic [ADDR_W-1:0]  inv_addr,
    output logic               err_flag
);
    logic [NUM_ENTRIES-1:0] e_valid, hit_bus, hit_rsp, hit_ack, hit_inv, alloc;
    rac_state_t             e_state [NUM_ENTRIES];
    logic [REQ_W-1:0]       e_id    [NUM_ENTRIES];
    logic [DATA_W-1:0]      e_data  [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        rac_entry #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_W(REQ_W), .ACK_W(ACK_W)
        ) u_entry (
            .clk(clk), .rst_n(rst_n), .alloc(alloc[g]),
            .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
            .bus_id(bus_id), .bus_wdata(bus_wdata),
            .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
            .rsp_acks(rsp_acks), .ack_valid(ack_valid), .ack_addr(ack_addr),
            .inv_valid(inv_valid), .inv_addr(inv_addr),
            .valid(e_valid[g]), .state(e_state[g]), .req_id(e_id[g]),
            .data(e_data[g]), .hit_bus(hit_bus[g]), .hit_rsp(hit_rsp[g]),
            .hit_ack(hit_ack[g]), .hit_inv(hit_inv[g])
        );
    end

    rac_state_t        sel_state;
    logic [DATA_W-1:0] sel_data;
    logic              bus_busy;
    logic              any_hit;

    // Mux out the state and data of the entry the bus access matched.
    always_comb begin
        sel_state = ST_PEND;
        sel_data  = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (hit_bus[i]) begin
                sel_state = e_state[i];
                sel_data  = e_data[i];
            end
        end
        any_hit  = |hit_bus;
        bus_busy = |(hit_bus & (hit_rsp | hit_ack | hit_inv));
    end

    // Pick the lowest free entry for a miss.
    always_comb begin
        logic found;
        found = 1'b0;
        alloc = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!e_valid[i] && !found && bus_valid && !any_hit) begin
                alloc[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    logic nx_retry, nx_hit, nx_nak;

    // Decide the bus answer for a read or read-exclusive.
    always_comb begin
        nx_retry = 1'b0;
        nx_hit   = 1'b0;
        nx_nak   = 1'b0;
        if (bus_valid && (bus_cmd != CMD_DFILL)) begin
            if (!any_hit || bus_busy) begin
                nx_retry = 1'b1;
            end else begin
                case (sel_state)
                    ST_READY, ST_SDIRTY: nx_hit = 1'b1;
                    ST_NAKD:             nx_nak = 1'b1;
                    ST_SHARED: begin
                        nx_hit   = (bus_cmd == CMD_READ);
                        nx_retry = (bus_cmd != CMD_READ);
                    end
                    default:             nx_retry = 1'b1;
                endcase
            end
        end
    end

    // Register the bus answer and the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_retry <= 1'b0;
            bus_hit   <= 1'b0;
            bus_nak   <= 1'b0;
            bus_rdata <= '0;
            err_flag  <= 1'b0;
        end else begin
            bus_retry <= nx_retry;
            bus_hit   <= nx_hit;
            bus_nak   <= nx_nak;
            bus_rdata <= nx_hit ? sel_data : '0;
            err_flag  <= err_flag || (rsp_valid && !(|hit_rsp))
                                  || (ack_valid && !(|hit_ack));
        end
    end

    // Block every requester that owns an entry still waiting for its reply.
    always_comb begin
        arb_mask = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (e_valid[i] && (e_state[i] == ST_PEND)) arb_mask[e_id[i]] = 1'b1;
        end
    end
endmodule

// File: rtl/rac_tracker_chk.sv
// Property checker for rac_tracker, attached by bind below.
// Assumes: hit vectors are the per-entry match outputs of the table.
module rac_tracker_chk #(
    parameter int NUM_ENTRIES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_valid,
    input logic [1:0]             bus_cmd,
    input logic                   bus_retry,
    input logic                   bus_hit,
    input logic                   bus_nak,
    input logic                   rsp_valid,
    input logic                   ack_valid,
    input logic                   err_flag,
    input logic [NUM_ENTRIES-1:0] hit_rsp,
    input logic [NUM_ENTRIES-1:0] hit_ack
);
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_retry, bus_hit, bus_nak}));                       // R2
    AST_ACCESS_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd != 2'b10) |=> (bus_retry || bus_hit || bus_nak)); // R2
    AST_NO_SPURIOUS_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_cmd != 2'b10) |=> !(bus_retry || bus_hit || bus_nak)); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);                                         // R11
    AST_ORPHAN_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && hit_rsp == '0) |=> err_flag);                     // R11
    AST_ORPHAN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && hit_ack == '0) |=> err_flag);                     // R11
    AST_SINGLE_REPLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_rsp));                                             // R4
endmodule

bind rac_tracker rac_tracker_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
    .bus_retry(bus_retry), .bus_hit(bus_hit), .bus_nak(bus_nak),
    .rsp_valid(rsp_valid), .ack_valid(ack_valid), .err_flag(err_flag),
    .hit_rsp(hit_rsp), .hit_ack(hit_ack)
);

// File: tb/tb_rac_tracker.sv
`timescale 1ns/1ps
module tb_rac_tracker;
    localparam logic [1:0] RD = 2'b00, RX = 2'b01, DF = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [1:0]  bus_cmd = 2'b00;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_id = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_retry, bus_hit, bus_nak;
    logic [31:0] bus_rdata;
    logic [3:0]  arb_mask;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_addr = '0;
    logic [31:0] rsp_data = '0;
    logic [3:0]  rsp_acks = '0;
    logic        ack_valid = 1'b0;
    logic [15:0] ack_addr = '0;
    logic        inv_valid = 1'b0;
    logic [15:0] inv_addr = '0;
    logic        err_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rac_tracker dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_id(bus_id), .bus_wdata(bus_wdata),
        .bus_retry(bus_retry), .bus_hit(bus_hit), .bus_nak(bus_nak),
        .bus_rdata(bus_rdata), .arb_mask(arb_mask),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .rsp_acks(rsp_acks), .ack_valid(ack_valid), .ack_addr(ack_addr),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .err_flag(err_flag)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One bus access; results are sampled one cycle later.
    task automatic bus_op(logic [1:0] cmd, logic [15:0] a, logic [1:0] id, logic [31:0] wd);
        bus_valid = 1'b1; bus_cmd = cmd; bus_addr = a; bus_id = id; bus_wdata = wd;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic expect_bus(string req, logic r, logic h, logic n, logic [31:0] d, logic [3:0] m);
        check(req, "retry", 32'(bus_retry), 32'(r));
        check(req, "hit",   32'(bus_hit),   32'(h));
        check(req, "nak",   32'(bus_nak),   32'(n));
        if (h) check(req, "rdata", bus_rdata, d);
        check(req, "mask",  32'(arb_mask),  32'(m));
    endtask

    task automatic reply(logic [15:0] a, logic [31:0] d, logic [3:0] n);
        rsp_valid = 1'b1; rsp_addr = a; rsp_data = d; rsp_acks = n;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic ack(logic [15:0] a);
        ack_valid = 1'b1; ack_addr = a;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic inval(logic [15:0] a);
        inv_valid = 1'b1; inv_addr = a;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        expect_bus("R1", 0, 0, 0, 0, 4'b0000);
        check("R1", "err", 32'(err_flag), 0);
    endtask

    task automatic t_read_flow();
        do_reset();
        bus_op(RD, 16'h0100, 2'd1, 0);  expect_bus("R2", 1, 0, 0, 0, 4'b0010);
        bus_op(RD, 16'h0100, 2'd1, 0);  expect_bus("R2 repeat", 1, 0, 0, 0, 4'b0010);
        reply(16'h0100, 32'hA0A0_0001, 0);
        check("R4", "mask after reply", 32'(arb_mask), 0);
        bus_op(RD, 16'h0100, 2'd1, 0);  expect_bus("R4", 0, 1, 0, 32'hA0A0_0001, 4'b0000);
        bus_op(RD, 16'h0100, 2'd2, 0);  expect_bus("R4 shared", 0, 1, 0, 32'hA0A0_0001, 4'b0000);
        bus_op(RX, 16'h0100, 2'd3, 0);  expect_bus("R12", 1, 0, 0, 0, 4'b1000);
        reply(16'h0100, 32'hB0B0_0002, 0);
        bus_op(RX, 16'h0100, 2'd3, 0);  expect_bus("R5", 0, 1, 0, 32'hB0B0_0002, 4'b0000);
        bus_op(RD, 16'h0100, 2'd0, 0);  expect_bus("R5 freed", 1, 0, 0, 0, 4'b0001);
        reply(16'h0100, 32'hC0C0_0003, 0);
        bus_op(RD, 16'h0100, 2'd0, 0);  expect_bus("R9 shared", 0, 1, 0, 32'hC0C0_0003, 4'b0000);
        inval(16'h0100);
        bus_op(RD, 16'h0100, 2'd2, 0);  expect_bus("R9 inv frees shared", 1, 0, 0, 0, 4'b0100);
        reply(16'h0100, 32'hC0C0_0004, 0);
        reply(16'h0100, 32'hDEAD_0000, 0);     // orphan: entry now ready, not pending
        check("R11", "err orphan reply", 32'(err_flag), 1);
        bus_op(RD, 16'h0100, 2'd2, 0);  expect_bus("R11 no change", 0, 1, 0, 32'hC0C0_0004, 4'b0000);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 4; i++) begin
            bus_op(RD, 16'h0200 + 16'(i), 2'(i), 0);
        end
        check("R2", "mask four", 32'(arb_mask), 32'hF);
        bus_op(RD, 16'h0500, 2'd0, 0);  expect_bus("R3", 1, 0, 0, 0, 4'b1111);
        check("R3", "err before", 32'(err_flag), 0);
        reply(16'h0500, 32'h1, 0);
        check("R3", "no entry allocated", 32'(err_flag), 1);
        check("R3", "mask kept", 32'(arb_mask), 32'hF);
    endtask

    task automatic t_ack_wait();
        do_reset();
        bus_op(RX, 16'h0300, 2'd2, 0);  expect_bus("R2 rx", 1, 0, 0, 0, 4'b0100);
        reply(16'h0300, 32'hD0D0_0005, 2);
        bus_op(RX, 16'h0300, 2'd2, 0);  expect_bus("R6", 0, 1, 0, 32'hD0D0_0005, 4'b0000);
        bus_op(RD, 16'h0300, 2'd1, 0);  expect_bus("R6 held", 1, 0, 0, 0, 4'b0000);
        ack(16'h0300);
        bus_op(RD, 16'h0300, 2'd1, 0);  expect_bus("R6 one ack", 1, 0, 0, 0, 4'b0000);
        ack(16'h0300);
        bus_op(RD, 16'h0300, 2'd1, 0);  expect_bus("R6 freed", 1, 0, 0, 0, 4'b0010);
        check("R6", "err", 32'(err_flag), 0);
    endtask

    task automatic t_early_ack();
        do_reset();
        bus_op(RX, 16'h0400, 2'd0, 0);
        reply(16'h0400, 32'hE0E0_0006, 1);
        ack(16'h0400);
        bus_op(RX, 16'h0400, 2'd0, 0);  expect_bus("R7", 0, 1, 0, 32'hE0E0_0006, 4'b0000);
        bus_op(RD, 16'h0400, 2'd3, 0);  expect_bus("R7 freed", 1, 0, 0, 0, 4'b1000);
        check("R7", "err", 32'(err_flag), 0);
    endtask

    task automatic t_stale();
        do_reset();
        bus_op(RD, 16'h0410, 2'd1, 0);
        inval(16'h0410);
        reply(16'h0410, 32'hF0F0_0007, 0);
        check("R8", "mask after reply", 32'(arb_mask), 0);
        bus_op(RD, 16'h0410, 2'd1, 0);  expect_bus("R8 nak", 0, 0, 1, 0, 4'b0000);
        bus_op(RD, 16'h0410, 2'd1, 0);  expect_bus("R8 freed", 1, 0, 0, 0, 4'b0010);
        bus_op(RX, 16'h0420, 2'd2, 0);
        inval(16'h0420);
        reply(16'h0420, 32'h1234_0008, 0);
        bus_op(RX, 16'h0420, 2'd2, 0);  expect_bus("R9 rx not stale", 0, 1, 0, 32'h1234_0008, 4'b0010);
    endtask

    task automatic t_dirty();
        do_reset();
        bus_op(DF, 16'h0600, 2'd3, 32'h5555_0009); expect_bus("R10 fill", 0, 0, 0, 0, 4'b0000);
        bus_op(RD, 16'h0600, 2'd0, 0);  expect_bus("R10 read", 0, 1, 0, 32'h5555_0009, 4'b0000);
        bus_op(RD, 16'h0600, 2'd1, 0);  expect_bus("R10 kept", 0, 1, 0, 32'h5555_0009, 4'b0000);
        bus_op(RX, 16'h0600, 2'd2, 0);  expect_bus("R10 rx", 0, 1, 0, 32'h5555_0009, 4'b0000);
        bus_op(RD, 16'h0600, 2'd2, 0);  expect_bus("R10 freed", 1, 0, 0, 0, 4'b0100);
    endtask

    task automatic t_orphan_ack();
        do_reset();
        ack(16'h0700);
        check("R11", "err orphan ack", 32'(err_flag), 1);
        @(negedge clk);
        check("R11", "err sticky", 32'(err_flag), 1);
        check("R11", "mask", 32'(arb_mask), 0);
    endtask

    initial begin
        t_reset();
        t_read_flow();
        t_full();
        t_ack_wait();
        t_early_ack();
        t_stale();
        t_dirty();
        t_orphan_ack();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule